// File: doc/BRIEF.md
# Indirect-Select Vectored Interrupt Controller

This block collects interrupt requests from up to 128 sources and turns them into one request line for a processor. Each source has its own priority and trigger type, plus a vector word and an enable bit. Software programs a source in two steps. First it writes the source's index into a select register. Then it uses the mode, vector and command registers, which act only on that one source. No per-bit mask words exist: enabling, disabling, clearing and forcing a request each take a select write followed by a command write.

The processor reads the vector register to take an interrupt. That read returns the vector of the best pending request and acknowledges it. The block pushes the winner's priority onto an eight-deep nesting stack and drops its edge latch. From then on, only a request of strictly higher priority can raise the request line. An end-of-interrupt write pops one level. If the vector register is read while nothing qualifies, it returns a programmable spurious value and changes nothing. Source inputs are taken to be already synchronous to the clock. Register reads are combinational within the access cycle, and their side effects happen at the closing clock edge.

Top module: `vic_top`

## Requirements
- R1: After reset the request output is low, no source is enabled, the nesting stack is empty, and a vector read returns the spurious value, which resets to 0.
- R2: A write to offset 0x00 stores the source index from bits 6:0. Offsets 0x04 (mode) and 0x08 (vector) read and write the entry of that selected source only. The mode word holds priority in bits 2:0, with 7 highest, and trigger type in bits 6:5. All other mode bits read 0.
- R3: A write of any data to 0x40 enables the selected source and a write to 0x44 disables it. No other source is affected. Offset 0x30 reads 1 in bit 0 when the selected source is enabled.
- R4: Trigger type 00 requests while the input is low. Type 10 requests while the input is high. For both, the request follows the input level.
- R5: Type 01 latches a rising edge and type 11 latches a falling edge. The latch holds until the source is acknowledged or until a write to 0x48 clears it while the source is selected.
- R6: A write to 0x4C forces a pending request on the selected source, whatever its trigger type.
- R7: Among enabled requesting sources, the highest priority wins and ties go to the lowest index. A read of 0x10 returns the winner's vector when the request output is high.
- R8: A read of 0x10 while the request output is low returns the value last written at 0x3C, and acknowledges nothing.
- R9: A vector read while the request output is high pushes the winner onto the nesting stack. Afterwards the output is high only for a request of strictly higher priority than the top entry. Offset 0x18 returns the index of the top entry, or 0 when the stack is empty.
- R10: A write to 0x38 pops one stack level, and does nothing when the stack is empty. Eight such writes always leave the stack empty.
- R11: Offset 0x34 reads the current state of the request output in bit 0.
- R12: A disabled source never raises the request output. An edge latched while the source is disabled is kept, and it requests as soon as the source is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIn | input | NSRC | Interrupt source inputs, synchronous to clk |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The arbiter is tried with a lone request, with two level requests of equal priority, and with a higher priority later given to the higher index. The first case shows the vector path works. The equal-priority pair shows whether ties break by index. The changed priority shows that priority outranks index. Edge sources are pulsed while disabled, then enabled, cleared, forced and acknowledged, which separates the latch from the level path. A ladder of eight rising priorities fills the stack, and the bench checks that a low request is held off and released only on the eighth end-of-interrupt. A long run of random selects, mode writes, commands, input toggles, acknowledges and pops is then checked against a bench-side model after every access.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 3;

  localparam logic [ADDR_W-1:0] OFS_SEL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_VEC  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_IVEC = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_CORE = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_SPUR = 8'h3C;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_SET  = 8'h4C;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_HIGH = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef enum logic [3:0] {
    RD_NONE, RD_SEL, RD_MODE, RD_VEC, RD_IVEC,
    RD_STAT, RD_MASK, RD_CORE, RD_SPUR
  } rdSrc_e;

  typedef struct packed {
    logic wrSel;
    logic wrMode;
    logic wrVec;
    logic wrSpur;
    logic cmdEn;
    logic cmdDis;
    logic cmdClr;
    logic cmdSet;
    logic eoi;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb,
  output rdSrc_e            rdSrc
);
  always_comb begin
    stb   = '0;
    rdSrc = RD_NONE;
    if (busSel && busWr) begin
      case (busAddr)
        OFS_SEL:  stb.wrSel  = 1'b1;
        OFS_MODE: stb.wrMode = 1'b1;
        OFS_VEC:  stb.wrVec  = 1'b1;
        OFS_SPUR: stb.wrSpur = 1'b1;
        OFS_EN:   stb.cmdEn  = 1'b1;
        OFS_DIS:  stb.cmdDis = 1'b1;
        OFS_CLR:  stb.cmdClr = 1'b1;
        OFS_SET:  stb.cmdSet = 1'b1;
        OFS_EOI:  stb.eoi    = 1'b1;
        default:  ;
      endcase
    end else if (busSel) begin
      case (busAddr)
        OFS_SEL:  rdSrc = RD_SEL;
        OFS_MODE: rdSrc = RD_MODE;
        OFS_VEC:  rdSrc = RD_VEC;
        OFS_IVEC: begin rdSrc = RD_IVEC; stb.ack = 1'b1; end
        OFS_STAT: rdSrc = RD_STAT;
        OFS_MASK: rdSrc = RD_MASK;
        OFS_CORE: rdSrc = RD_CORE;
        OFS_SPUR: rdSrc = RD_SPUR;
        default:  rdSrc = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcIn,
  input  strobe_t           stb,
  input  rdSrc_e            rdSrc,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut
);
  localparam int SEL_W  = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DCNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SEL_W-1:0]  selQ;
  logic              selValid;
  logic [PRIO_W-1:0] modePrio [NSRC];
  trig_e             modeType [NSRC];
  logic [DATA_W-1:0] vecQ     [NSRC];
  logic [DATA_W-1:0] spurQ;
  logic [NSRC-1:0]   enQ, pendQ, prevQ;
  logic [NSRC-1:0]   levelReq, raise, drop, enSet, enClr, active;

  logic [PRIO_W-1:0] stackPrio [DEPTH];
  logic [SEL_W-1:0]  stackIdx  [DEPTH];
  logic [DCNT_W-1:0] depthQ;
  logic [PTR_W-1:0]  topPtr, pushPtr;

  logic              found, irqInt, ackTake, popTake;
  logic [SEL_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;

  generate
    if (NSRC == (1 << SEL_W)) begin : g_selFull
      assign selValid = 1'b1;
    end else begin : g_selPart
      assign selValid = (32'(selQ) < NSRC);
    end
  endgenerate

  // Select register, per-source configuration and spurious value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      spurQ <= '0;
      for (int i = 0; i < NSRC; i++) begin
        modePrio[i] <= '0;
        modeType[i] <= TRIG_LOW;
        vecQ[i]     <= '0;
      end
    end else begin
      if (stb.wrSel)  selQ  <= wdata[SEL_W-1:0];
      if (stb.wrSpur) spurQ <= wdata;
      if (stb.wrMode && selValid) begin
        modePrio[selQ] <= wdata[PRIO_W-1:0];
        modeType[selQ] <= trig_e'(wdata[6:5]);
      end
      if (stb.wrVec && selValid) vecQ[selQ] <= wdata;
    end
  end

  // Per-source trigger decode and command targeting
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic hitSel, newEdge;
      assign hitSel  = selValid && (selQ == SEL_W'(g));
      assign newEdge = ((modeType[g] == TRIG_RISE) &&  srcIn[g] && !prevQ[g]) ||
                       ((modeType[g] == TRIG_FALL) && !srcIn[g] &&  prevQ[g]);
      assign levelReq[g] = ((modeType[g] == TRIG_HIGH) &&  srcIn[g]) ||
                           ((modeType[g] == TRIG_LOW)  && !srcIn[g]);
      assign raise[g] = newEdge || (stb.cmdSet && hitSel);
      assign drop[g]  = (stb.cmdClr && hitSel) || (ackTake && (bestIdx == SEL_W'(g)));
      assign enSet[g] = stb.cmdEn  && hitSel;
      assign enClr[g] = stb.cmdDis && hitSel;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= '0;
      pendQ <= '0;
      prevQ <= '0;
    end else begin
      enQ   <= (enQ & ~enClr) | enSet;
      pendQ <= (pendQ & ~drop) | raise;
      prevQ <= srcIn;
    end
  end

  assign active = (levelReq | pendQ) & enQ;

  // Linear priority scan: strict compare keeps the lowest index on ties
  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!found || (modePrio[i] > bestPrio))) begin
        found    = 1'b1;
        bestIdx  = SEL_W'(i);
        bestPrio = modePrio[i];
      end
    end
  end

  assign topPtr  = PTR_W'(depthQ - 1'b1);
  assign pushPtr = PTR_W'(depthQ);
  assign irqInt  = found && ((depthQ == '0) || (bestPrio > stackPrio[topPtr]));
  assign ackTake = stb.ack && irqInt;
  assign popTake = stb.eoi && (depthQ != '0);
  assign irqOut  = irqInt;

  // Nesting stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        stackPrio[i] <= '0;
        stackIdx[i]  <= '0;
      end
    end else if (ackTake && (depthQ < DCNT_W'(DEPTH))) begin
      stackPrio[pushPtr] <= bestPrio;
      stackIdx[pushPtr]  <= bestIdx;
      depthQ             <= depthQ + 1'b1;
    end else if (popTake) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  always_comb begin
    case (rdSrc)
      RD_SEL:  rdata = DATA_W'(selQ);
      RD_MODE: rdata = selValid ? {{(DATA_W-7){1'b0}}, modeType[selQ], 2'b00, modePrio[selQ]} : '0;
      RD_VEC:  rdata = selValid ? vecQ[selQ] : '0;
      RD_IVEC: rdata = irqInt ? vecQ[bestIdx] : spurQ;
      RD_STAT: rdata = (depthQ != '0) ? DATA_W'(stackIdx[topPtr]) : '0;
      RD_MASK: rdata = {{(DATA_W-1){1'b0}}, enQ[selQ] & selValid};
      RD_CORE: rdata = {{(DATA_W-1){1'b0}}, irqInt};
      RD_SPUR: rdata = spurQ;
      default: rdata = '0;
    endcase
  end

  // R10
  stack_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackTake |-> (depthQ < DCNT_W'(DEPTH)));
  // R9
  ack_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && irqOut) |=> (depthQ == DCNT_W'($past(depthQ) + 1'b1)));
  // R8
  spur_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !irqOut) |=> (depthQ == $past(depthQ)));
  // R10
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && (depthQ != '0)) |=> (depthQ == DCNT_W'($past(depthQ) - 1'b1)));
  // R3
  enable_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdEn && selValid) |=> enQ[$past(selQ)]);
  // R6
  set_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cmdSet && selValid) |=> pendQ[$past(selQ)]);
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NSRC  = 128,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcIn,
  input  logic            busSel,
  input  logic            busWr,
  input  logic [7:0]      busAddr,
  input  logic [31:0]     busWdata,
  output logic [31:0]     busRdata,
  output logic            irqOut
);
  strobe_t stb;
  rdSrc_e  rdSrc;

  vic_ctrl u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb),
    .rdSrc   (rdSrc)
  );

  vic_datapath #(.NSRC(NSRC), .DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .stb    (stb),
    .rdSrc  (rdSrc),
    .wdata  (busWdata),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
  localparam int NSRC = 128;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcIn = '0;
  logic [NSRC-1:0] srcNext = '0;
  logic            busSel = 1'b0, busWr = 1'b0;
  logic [7:0]      busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic            irqOut;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] lastRd;

  // bench model
  bit [NSRC-1:0] mEn = '0, mPend = '0, mPrev = '0;
  bit [2:0]  mPrio [NSRC];
  bit [1:0]  mType [NSRC];
  bit [31:0] mVec  [NSRC];
  bit [6:0]  mSel = '0;
  bit [31:0] mSpur = '0;
  bit [2:0]  stP [8];
  bit [6:0]  stI [8];
  int        mDepth = 0;

  always #2 clk = ~clk;

  vic_top dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit reqOf(int i);
    bit lv;
    lv = (mType[i] == 2'b00 && !srcIn[i]) || (mType[i] == 2'b10 && srcIn[i]);
    return lv || mPend[i];
  endfunction

  function automatic void winner(output bit f, output int bi, output int bp);
    f = 0; bi = 0; bp = 0;
    for (int i = 0; i < NSRC; i++)
      if (mEn[i] && reqOf(i) && (!f || int'(mPrio[i]) > bp)) begin
        f = 1; bi = i; bp = int'(mPrio[i]);
      end
  endfunction

  function automatic bit expIrq();
    bit f; int bi, bp;
    winner(f, bi, bp);
    return f && (mDepth == 0 || bp > int'(stP[mDepth-1]));
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a);
    bit f; int bi, bp;
    winner(f, bi, bp);
    case (a)
      8'h00: return {25'b0, mSel};
      8'h04: return {25'b0, mType[mSel], 2'b00, mPrio[mSel]};
      8'h08: return mVec[mSel];
      8'h10: return expIrq() ? mVec[bi] : mSpur;
      8'h18: return (mDepth > 0) ? {25'b0, stI[mDepth-1]} : 32'd0;
      8'h30: return {31'b0, mEn[mSel]};
      8'h34: return {31'b0, expIrq()};
      8'h3C: return mSpur;
      default: return 32'd0;
    endcase
  endfunction

  task automatic modelStep(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d);
    bit [NSRC-1:0] raise, drop;
    bit f, irq; int bi, bp;
    raise = '0; drop = '0;
    winner(f, bi, bp);
    irq = expIrq();
    for (int i = 0; i < NSRC; i++) begin
      if (mType[i] == 2'b01 && srcIn[i] && !mPrev[i]) raise[i] = 1;
      if (mType[i] == 2'b11 && !srcIn[i] && mPrev[i]) raise[i] = 1;
    end
    if (s && w) begin
      case (a)
        8'h00: mSel = d[6:0];
        8'h04: begin mPrio[mSel] = d[2:0]; mType[mSel] = d[6:5]; end
        8'h08: mVec[mSel] = d;
        8'h3C: mSpur = d;
        8'h40: mEn[mSel] = 1;
        8'h44: mEn[mSel] = 0;
        8'h48: drop[mSel] = 1;
        8'h4C: raise[mSel] = 1;
        8'h38: if (mDepth > 0) mDepth--;
        default: ;
      endcase
    end
    if (s && !w && a == 8'h10 && irq) begin
      stP[mDepth] = 3'(bp); stI[mDepth] = 7'(bi); mDepth++; drop[bi] = 1;
    end
    mPend = (mPend & ~drop) | raise;
    mPrev = srcIn;
  endtask

  // one bus cycle; the request output is compared every cycle (R7, R9)
  task automatic cyc(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    srcIn = srcNext; busSel = s; busWr = w; busAddr = a; busWdata = d;
    #1;
    chk("R9 request output", {31'b0, irqOut}, {31'b0, expIrq()});
    lastRd = busRdata;
    if (s && !w) chk(tag, busRdata, expRead(a));
    modelStep(s, w, a, d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 1, a, d, "");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1, 0, a, 0, tag);
  endtask
  task automatic idle();
    cyc(0, 0, 8'h00, 0, "");
  endtask
  task automatic cfg(input int idx, input int pr, input bit [1:0] ty, input logic [31:0] v, input bit en);
    wr(8'h00, idx); wr(8'h04, {25'b0, ty, 2'b00, 3'(pr)}); wr(8'h08, v);
    wr(en ? 8'h40 : 8'h44, 0);
  endtask
  task automatic dis(input int idx);
    wr(8'h00, idx); wr(8'h44, 0);
  endtask

  function automatic int pick();
    case ($urandom % 6)
      0: return 0; 1: return 3; 2: return 9; 3: return 63; 4: return 64;
      default: return 127;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NSRC; i++) begin mPrio[i] = 0; mType[i] = 0; mVec[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk("R1 irq in reset", {31'b0, irqOut}, 32'd0);
    rstN = 1'b1;

    // R1 after reset
    rd(8'h10, "R1 vector read");
    chk("R1 spurious reset", lastRd, 32'd0);
    rd(8'h18, "R1 status"); rd(8'h30, "R1 mask"); rd(8'h34, "R11 core");

    // R2 selected entry access
    wr(8'h00, 5); wr(8'h04, 32'h63); wr(8'h08, 32'hA5A5_0005);
    wr(8'h00, 6); wr(8'h04, 32'h12); rd(8'h04, "R2 mode 6");
    wr(8'h00, 5); rd(8'h04, "R2 mode 5");
    chk("R2 mode readback", lastRd, 32'h63);
    rd(8'h08, "R2 vector 5");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, "R2 mode bits");
    chk("R2 unused mode bits", lastRd, 32'h67);
    rd(8'h00, "R2 select");

    // R8 spurious
    wr(8'h3C, 32'hDEAD_BEEF); rd(8'h10, "R8 spurious");
    chk("R8 spurious value", lastRd, 32'hDEAD_BEEF);

    // R4 level high
    cfg(2, 4, 2'b10, 32'h200, 1); rd(8'h30, "R3 mask");
    chk("R3 mask set", lastRd, 32'd1);
    srcNext[2] = 1; idle(); rd(8'h34, "R11 level high");
    chk("R4 level high", lastRd, 32'd1);
    srcNext[2] = 0; idle(); rd(8'h34, "R4 level released");
    chk("R4 level high off", lastRd, 32'd0);
    dis(2);
    // R4 level low
    cfg(41, 3, 2'b00, 32'h41, 1); rd(8'h34, "R4 level low");
    chk("R4 level low", lastRd, 32'd1);
    srcNext[41] = 1; idle(); rd(8'h34, "R4 level low off");
    chk("R4 level low off", lastRd, 32'd0);
    dis(41); rd(8'h30, "R3 mask clear");
    chk("R3 mask cleared", lastRd, 32'd0);
    srcNext[41] = 0; idle();

    // R7 tie and priority
    cfg(20, 5, 2'b10, 32'h20, 1); cfg(21, 5, 2'b10, 32'h21, 1);
    srcNext[20] = 1; srcNext[21] = 1; idle();
    rd(8'h10, "R7 tie"); chk("R7 tie lowest index", lastRd, 32'h20);
    rd(8'h18, "R9 status"); chk("R9 status index", lastRd, 32'd20);
    rd(8'h34, "R9 same prio held"); chk("R9 equal prio held", lastRd, 32'd0);
    wr(8'h38, 0);
    wr(8'h00, 21); wr(8'h04, {25'b0, 2'b10, 2'b00, 3'd6}); idle();
    rd(8'h10, "R7 higher prio"); chk("R7 priority wins", lastRd, 32'h21);
    wr(8'h38, 0); dis(20); dis(21); srcNext[20] = 0; srcNext[21] = 0; idle();

    // R5 / R12 edges
    cfg(30, 2, 2'b01, 32'h30, 0);
    srcNext[30] = 1; idle(); srcNext[30] = 0; idle();
    rd(8'h34, "R12 disabled"); chk("R12 disabled silent", lastRd, 32'd0);
    wr(8'h00, 30); wr(8'h40, 0); rd(8'h34, "R12 retained");
    chk("R12 latch retained", lastRd, 32'd1);
    wr(8'h48, 0); rd(8'h34, "R5 clear"); chk("R5 clear drops", lastRd, 32'd0);
    cfg(31, 2, 2'b11, 32'h31, 1);
    srcNext[31] = 1; idle(); rd(8'h34, "R5 no fall yet");
    chk("R5 rise ignored by fall type", lastRd, 32'd0);
    srcNext[31] = 0; idle(); rd(8'h34, "R5 fall");
    chk("R5 falling edge", lastRd, 32'd1);
    rd(8'h10, "R5 ack"); chk("R5 vector", lastRd, 32'h31);
    wr(8'h38, 0); rd(8'h34, "R5 ack clears");
    chk("R5 ack cleared latch", lastRd, 32'd0);
    dis(30); dis(31);

    // R6 set command
    cfg(40, 1, 2'b01, 32'h40, 1); wr(8'h4C, 0);
    rd(8'h34, "R6 set"); chk("R6 forced", lastRd, 32'd1);
    rd(8'h10, "R6 vector"); chk("R6 vector", lastRd, 32'h40);
    wr(8'h38, 0); dis(40);

    // R9 / R10 nesting ladder
    for (int k = 0; k < 8; k++) cfg(10 + k, k, 2'b01, 32'h100 + k, 1);
    for (int k = 0; k < 8; k++) begin
      srcNext[10 + k] = 1; idle(); srcNext[10 + k] = 0; idle();
      rd(8'h10, "R9 nest ack"); chk("R9 nest vector", lastRd, 32'h100 + k);
    end
    rd(8'h18, "R9 top"); chk("R9 top index", lastRd, 32'd17);
    srcNext[10] = 1; idle(); srcNext[10] = 0; idle();
    for (int k = 0; k < 7; k++) begin
      wr(8'h38, 0); rd(8'h34, "R9 held off"); chk("R9 lower held", lastRd, 32'd0);
    end
    wr(8'h38, 0); rd(8'h34, "R10 unwound"); chk("R10 eight pops", lastRd, 32'd1);
    wr(8'h38, 0); rd(8'h18, "R10 empty pop"); chk("R10 pop on empty", lastRd, 32'd0);
    rd(8'h10, "R7 after unwind"); chk("R7 low vector", lastRd, 32'h100);
    wr(8'h38, 0);
    for (int k = 0; k < 8; k++) dis(10 + k);

    // random phase
    for (int it = 0; it < 3000; it++) begin
      case ($urandom % 14)
        0:  wr(8'h00, pick());
        1:  wr(8'h04, $urandom);
        2:  wr(8'h08, $urandom);
        3:  wr(8'h40, 0);
        4:  wr(8'h44, 0);
        5:  wr(8'h48, 0);
        6:  wr(8'h4C, 0);
        7:  begin int p; p = pick(); srcNext[p] = ~srcNext[p]; idle(); end
        8, 9: rd(8'h10, "R7 random vector");
        10: wr(8'h38, 0);
        11: rd(8'h18, "R9 random status");
        12: rd(8'h30, "R3 random mask");
        default: rd(8'h04, "R2 random mode");
      endcase
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule